// File: doc/BRIEF.md
# Resistive Majority Compute Array

A cycle-level model of a small bank of one-bit resistive cells. In this bank, storing a bit and computing with it are the same event. Each cell has two terminal signals, P and Q. An update instruction replaces the cell's content Z with the three-input majority of P, the complement of Q, and Z itself. Driving P high with Q low sets the cell. Driving P low with Q high clears it. Equal terminals leave the cell alone. Because of this rule, a cell that already holds 0 evaluates an AND of the two operands. A cell that holds 1 evaluates an OR.

Instructions arrive one per clock, qualified by a valid strobe. An instruction can read a cell, preset a cell to 0 or 1, or apply a majority update. For an update, each terminal is taken from a constant, from another cell, or from the complement of another cell. A Boolean function is therefore written as a short list of presets followed by in-place majority updates. Two counters report how many majority updates and how many read or preset cycles a sequence has consumed.

Top module: `rmaj_array`

## Requirements
- R1: A synchronous active-high reset clears every cell, both counters and `rd_valid` to 0.
- R2: Each terminal source select uses the encoding 0 = constant 0, 1 = constant 1, 2 = content of the cell at its address, 3 = complement of that content.
- R3: Opcode 3 (majority) with `instr_valid` high writes maj(P, not Q, Z) into the addressed cell, where Z is its current content. P=1 with Q=0 gives 1, and P=0 with Q=1 gives 0.
- R4: A majority instruction whose P and Q values are equal leaves the addressed cell unchanged.
- R5: Operand values are taken from the array as it stands before the clock edge, so an instruction that uses its own target as a source sees the old Z.
- R6: Opcode 1 presets the addressed cell to 0, and opcode 2 presets it to 1.
- R7: Opcode 0 (read) raises `rd_valid` on the following cycle, with `rd_data` equal to the addressed cell, and changes no cell.
- R8: `maj_count` increments once per accepted majority instruction. `rw_count` increments once per accepted read or preset.
- R9: With `instr_valid` low, no cell and no counter changes.
- R10: Preset-then-majority sequences compute AND (from a cleared cell), OR (from a set cell) and three-input majority (from a cell preset to the third input). This holds for all 16 patterns of four input cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction strobe |
| instr_op | input | 2 | 0 read, 1 preset 0, 2 preset 1, 3 majority |
| instr_addr | input | AW | Target cell |
| p_sel | input | 2 | P source select |
| p_addr | input | AW | P source cell |
| q_sel | input | 2 | Q source select |
| q_addr | input | AW | Q source cell |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 1 | Read result |
| maj_count | output | CNT_W | Majority instructions since reset |
| rw_count | output | CNT_W | Read and preset instructions since reset |

## Verification
The hardest case to reach from the ports is an instruction that reads the same cell it writes. Its outcome depends on whether the operand is sampled before or after the update. The bench provokes this with self-referencing updates in both polarities, and each one is followed by a read. A full sweep over four input cells then runs a composed AND/OR/majority program for every pattern. The results are compared against arithmetic in the bench, and the counters are checked against the instruction tally.

// File: rtl/rmaj_array.sv
module rmaj_array #(
  parameter int CELLS = 16,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [1:0]       instr_op,
  input  logic [AW-1:0]    instr_addr,
  input  logic [1:0]       p_sel,
  input  logic [AW-1:0]    p_addr,
  input  logic [1:0]       q_sel,
  input  logic [AW-1:0]    q_addr,
  output logic             rd_valid,
  output logic             rd_data,
  output logic [CNT_W-1:0] maj_count,
  output logic [CNT_W-1:0] rw_count
);

  logic [CELLS-1:0] cells;
  logic p_val, q_val, z_cur, z_next;

  always_comb begin
    case (p_sel)
      2'd0:    p_val = 1'b0;
      2'd1:    p_val = 1'b1;
      2'd2:    p_val = cells[p_addr];
      default: p_val = ~cells[p_addr];
    endcase
    case (q_sel)
      2'd0:    q_val = 1'b0;
      2'd1:    q_val = 1'b1;
      2'd2:    q_val = cells[q_addr];
      default: q_val = ~cells[q_addr];
    endcase
  end

  assign z_cur  = cells[instr_addr];
  assign z_next = (p_val & ~q_val) | (p_val & z_cur) | (~q_val & z_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      cells     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= 1'b0;
      maj_count <= '0;
      rw_count  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (instr_valid) begin
        case (instr_op)
          2'd0: begin
            rd_valid <= 1'b1;
            rd_data  <= z_cur;
            rw_count <= rw_count + 1'b1;
          end
          2'd1: begin
            cells[instr_addr] <= 1'b0;
            rw_count <= rw_count + 1'b1;
          end
          2'd2: begin
            cells[instr_addr] <= 1'b1;
            rw_count <= rw_count + 1'b1;
          end
          default: begin
            cells[instr_addr] <= z_next;
            maj_count <= maj_count + 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/rmaj_array_chk.sv
module rmaj_array_chk #(
  parameter int CELLS = 16,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(CELLS)
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_valid,
  input logic [1:0]       instr_op,
  input logic [AW-1:0]    instr_addr,
  input logic             p_val,
  input logic             q_val,
  input logic [CELLS-1:0] cells,
  input logic             rd_valid,
  input logic [CNT_W-1:0] maj_count,
  input logic [CNT_W-1:0] rw_count
);

  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_op == 2'd3 && p_val && !q_val |=> cells[$past(instr_addr)]);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_op == 2'd3 && !p_val && q_val |=> !cells[$past(instr_addr)]);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_op == 2'd3 && p_val == q_val
    |=> cells[$past(instr_addr)] == $past(cells[instr_addr]));

  p_read_r7: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_op == 2'd0 |=> rd_valid && $stable(cells));

  p_majcnt_r8: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_op == 2'd3 |=> maj_count == $past(maj_count) + 1'b1);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> $stable(cells) && $stable(maj_count) && $stable(rw_count));

endmodule

bind rmaj_array rmaj_array_chk #(.CELLS(CELLS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
  .instr_addr(instr_addr), .p_val(p_val), .q_val(q_val), .cells(cells),
  .rd_valid(rd_valid), .maj_count(maj_count), .rw_count(rw_count)
);

// File: tb/rmaj_array_bench.sv
module rmaj_array_bench;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [1:0] instr_op = '0, p_sel = '0, q_sel = '0;
  logic [3:0] instr_addr = '0, p_addr = '0, q_addr = '0;
  logic rd_valid, rd_data;
  logic [CNT_W-1:0] maj_count, rw_count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rmaj_array u_rmaj_array (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .p_sel(p_sel), .p_addr(p_addr), .q_sel(q_sel),
    .q_addr(q_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .maj_count(maj_count), .rw_count(rw_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [3:0] a,
                       input logic [1:0] ps, input logic [3:0] pa,
                       input logic [1:0] qs, input logic [3:0] qa);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    p_sel = ps; p_addr = pa; q_sel = qs; q_addr = qa;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic preset(input logic [3:0] a, input logic v);
    issue(v ? 2'd2 : 2'd1, a, 2'd0, 4'd0, 2'd0, 4'd0);
  endtask

  task automatic maj(input logic [3:0] a, input logic [1:0] ps, input logic [3:0] pa,
                     input logic [1:0] qs, input logic [3:0] qa);
    issue(2'd3, a, ps, pa, qs, qa);
  endtask

  task automatic rd(input logic [3:0] a, input string req, input logic exp);
    issue(2'd0, a, 2'd0, 4'd0, 2'd0, 4'd0);
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk(req, int'(rd_data), int'(exp));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int rwc, mjc;
    do_reset();
    // R1 reset state
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 maj_count", int'(maj_count), 0);
    chk("R1 rw_count", int'(rw_count), 0);
    for (int i = 0; i < 16; i++) rd(4'(i), "R1 cell", 1'b0);

    // R6 presets, R7 read leaves content
    preset(4'd2, 1'b1);
    rd(4'd2, "R6 preset1", 1'b1);
    rd(4'd2, "R7 reread", 1'b1);
    preset(4'd2, 1'b0);
    rd(4'd2, "R6 preset0", 1'b0);

    // R3 / R4 single-cell truth table with constant terminals
    for (int v = 0; v < 8; v++) begin
      logic z, p, q;
      z = v[0]; p = v[1]; q = v[2];
      preset(4'd9, z);
      maj(4'd9, {1'b0, p}, 4'd0, {1'b0, q}, 4'd0);
      rd(4'd9, (p == q) ? "R4 hold" : "R3 maj", (p & ~q) | (p & z) | (~q & z));
    end

    // R5 self reference uses old value
    preset(4'd10, 1'b0);
    maj(4'd10, 2'd1, 4'd0, 2'd2, 4'd10);
    rd(4'd10, "R5 self Q set", 1'b1);
    maj(4'd10, 2'd0, 4'd0, 2'd2, 4'd10);
    rd(4'd10, "R5 self Q clear", 1'b0);
    maj(4'd10, 2'd2, 4'd10, 2'd1, 4'd0);
    rd(4'd10, "R5 self P hold", 1'b0);

    // R2 complement source
    preset(4'd13, 1'b0);
    preset(4'd12, 1'b0);
    maj(4'd12, 2'd3, 4'd13, 2'd0, 4'd0);
    rd(4'd12, "R2 complement src", 1'b1);
    preset(4'd11, 1'b1);
    maj(4'd12, 2'd0, 4'd0, 2'd2, 4'd11);
    rd(4'd12, "R2 cell src", 1'b0);

    // R9 valid low is ignored
    preset(4'd14, 1'b0);
    rwc = int'(rw_count); mjc = int'(maj_count);
    instr_op = 2'd2; instr_addr = 4'd14; instr_valid = 1'b0;
    @(negedge clk);
    instr_op = 2'd3; p_sel = 2'd1; q_sel = 2'd0;
    @(negedge clk);
    chk("R9 rw_count", int'(rw_count), rwc);
    chk("R9 maj_count", int'(maj_count), mjc);
    rd(4'd14, "R9 cell", 1'b0);

    // R10 / R8 composed program over all 16 patterns
    for (int v = 0; v < 16; v++) begin
      logic a, b, c, d;
      a = v[0]; b = v[1]; c = v[2]; d = v[3];
      do_reset();
      preset(4'd0, a); preset(4'd1, b); preset(4'd2, c); preset(4'd3, d);
      preset(4'd4, 1'b0); preset(4'd5, 1'b0); preset(4'd6, 1'b1); preset(4'd7, c);
      maj(4'd4, 2'd2, 4'd0, 2'd3, 4'd1);
      maj(4'd5, 2'd2, 4'd2, 2'd3, 4'd3);
      maj(4'd6, 2'd2, 4'd4, 2'd3, 4'd5);
      maj(4'd7, 2'd2, 4'd0, 2'd3, 4'd1);
      rd(4'd6, "R10 and-or", (a & b) | (c & d));
      rd(4'd7, "R10 maj3", (a & b) | (a & c) | (b & c));
      chk("R8 maj_count", int'(maj_count), 4);
      chk("R8 rw_count", int'(rw_count), 10);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule